// File: doc/BRIEF.md
# Analog Loss-of-Signal Alarm Timer

This block sits behind a receive-amplitude comparator whose output is high while the line level is under the loss threshold. The comparator already applies hysteresis, so the block does not filter the flag. It synchronizes the flag to the system clock and measures how long the flag stays high. When that time reaches the selected window, it declares a loss-of-signal alarm.

Two windows are available:
- A millisecond window of about 1.5 ms. Its clock count is computed from the system clock frequency.
- A symbol window, a fixed number of line-symbol periods, each a whole number of system clocks.

A sticky status bit records every declaration and is cleared by a status-read strobe. A maskable interrupt pulse marks each new declaration. When long-haul equalization is selected, the whole function is held off.

Top module: `alos_timer`

## Requirements
- R1: With `win_sel_i` = 0, after `lost_i` goes high and stays high, `alarm_o` rises on the (MS_CYC + SYNC_STAGES)-th rising edge, counting the first edge that samples `lost_i` high. MS_CYC = CLK_KHZ*MS_WIN_US/1000. It is low on the edge before.
- R2: With `win_sel_i` = 1, the same rule applies with SYM_CYC*SYM_WIN in place of MS_CYC. SYM_WIN lies between 10 and 255.
- R3: A low level on the synchronized `lost_i` clears the elapsed time. A new loss after any gap is timed again from zero.
- R4: After `lost_i` falls, `alarm_o` goes low on the (SYNC_STAGES+1)-th rising edge, counting the first edge that samples it low.
- R5: While `long_haul_i` = 1, `alarm_o` is low from the first edge on, and `status_o` and `irq_o` cannot be set. Once `long_haul_i` returns to 0 with loss still present, the window is timed again from zero.
- R6: `status_o` is set one edge after `alarm_o` is seen high. It stays set after `alarm_o` falls.
- R7: A clock cycle with `rd_stb_i` = 1 clears `status_o` on that edge. If `alarm_o` is still high, `status_o` is set again on the next edge.
- R8: `irq_o` is a one-cycle pulse one edge after `alarm_o` rises, and only when `irq_en_i` = 1 at that time. With `irq_en_i` = 0 it never pulses.
- R9: While `rst_ni` is low, `alarm_o`, `status_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lost_i | input | 1 | Comparator flag: amplitude below threshold (asynchronous) |
| win_sel_i | input | 1 | Window select: 0 = millisecond, 1 = symbol periods |
| long_haul_i | input | 1 | Long-haul equalization selected; disables the alarm |
| irq_en_i | input | 1 | Interrupt enable |
| rd_stb_i | input | 1 | Status-read strobe, one cycle |
| alarm_o | output | 1 | Live loss-of-signal alarm |
| status_o | output | 1 | Sticky alarm status, cleared on read |
| irq_o | output | 1 | Interrupt pulse on a new declaration |

## Verification
The bench counts each delay from the first rising edge that samples a changed input. Rise checks fall one edge apart:
- `alarm_o`: due window+2 edges after the loss with two synchronizer stages. Each window is checked at that edge and at the edge before it.
- `status_o` and `irq_o`: due one edge after `alarm_o`.
- Alarm clear: due three edges after the loss ends.
- Long-haul gating: due on the first edge.

Inputs change just after a falling edge, and outputs are sampled just after later falling edges. Each check is therefore taken an exact whole number of edges after its stimulus.

// File: rtl/alos_pkg.sv
`timescale 1ns/1ps
package alos_pkg;
  typedef enum logic {
    WIN_MS  = 1'b0,
    WIN_SYM = 1'b1
  } win_sel_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/alos_sync.sv
`timescale 1ns/1ps
module alos_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[i] <= 1'b0;
        else         ff_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[i] <= 1'b0;
        else         ff_q[i] <= ff_q[i-1];
      end
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/alos_win_timer.sv
`timescale 1ns/1ps
module alos_win_timer
  import alos_pkg::*;
#(
  parameter int unsigned MS_LIMIT  = 12288,
  parameter int unsigned SYM_LIMIT = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lost_i,
  input  logic win_sel_i,
  input  logic long_haul_i,
  output logic alarm_o
);
  localparam int unsigned MAX_LIMIT = max_u(MS_LIMIT, SYM_LIMIT);
  localparam int unsigned CNT_W     = $clog2(MAX_LIMIT + 1);

  logic [CNT_W-1:0] cnt_q, limit;
  logic             active, alarm_q;

  assign active = lost_i & ~long_haul_i;

  always_comb begin
    if (win_sel_e'(win_sel_i) == WIN_SYM) limit = CNT_W'(SYM_LIMIT);
    else                                  limit = CNT_W'(MS_LIMIT);
  end

  // count saturates at the window; restart on any present-signal cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!active)        cnt_q <= '0;
    else if (cnt_q < limit)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alarm_q <= 1'b0;
    else         alarm_q <= active && (cnt_q >= limit - 1'b1);
  end

  assign alarm_o = alarm_q;

  // R5
  lh_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_haul_i |=> !alarm_q);

  // R3
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lost_i |=> (cnt_q == '0));

  // R4
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lost_i |=> !alarm_q);
endmodule

// File: rtl/alos_status.sv
`timescale 1ns/1ps
module alos_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alarm_i,
  input  logic rd_stb_i,
  input  logic irq_en_i,
  output logic status_o,
  output logic irq_o
);
  logic prev_q, sts_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      sts_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= alarm_i;
      irq_q  <= irq_en_i & alarm_i & ~prev_q;
      // read wins; a still-active alarm re-sets the bit a cycle later
      sts_q  <= rd_stb_i ? 1'b0 : (sts_q | alarm_i);
    end
  end

  assign status_o = sts_q;
  assign irq_o    = irq_q;

  // R7
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_i |=> !sts_q);

  // R6
  sts_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_i && !rd_stb_i) |=> sts_q);

  // R8
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);

  // R8
  irq_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(irq_en_i));
endmodule

// File: rtl/alos_timer.sv
`timescale 1ns/1ps
module alos_timer #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CLK_KHZ     = 8192,
  parameter int unsigned MS_WIN_US   = 1500,
  parameter int unsigned SYM_CYC     = 4,
  parameter int unsigned SYM_WIN     = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lost_i,
  input  logic win_sel_i,
  input  logic long_haul_i,
  input  logic irq_en_i,
  input  logic rd_stb_i,
  output logic alarm_o,
  output logic status_o,
  output logic irq_o
);
  localparam int unsigned MS_LIMIT  = (CLK_KHZ * MS_WIN_US) / 1000;
  localparam int unsigned SYM_LIMIT = SYM_CYC * SYM_WIN;

  logic lost_s, alarm;

  alos_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lost_i),
    .q_o    (lost_s)
  );

  alos_win_timer #(.MS_LIMIT(MS_LIMIT), .SYM_LIMIT(SYM_LIMIT)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lost_i      (lost_s),
    .win_sel_i   (win_sel_i),
    .long_haul_i (long_haul_i),
    .alarm_o     (alarm)
  );

  alos_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .alarm_i  (alarm),
    .rd_stb_i (rd_stb_i),
    .irq_en_i (irq_en_i),
    .status_o (status_o),
    .irq_o    (irq_o)
  );

  assign alarm_o = alarm;
endmodule

// File: tb/alos_timer_bench.sv
`timescale 1ns/1ps
module alos_timer_bench;
  // ms window = 20*1500/1000 = 30 cycles; symbol window = 2*12 = 24 cycles
  localparam int unsigned MS_LIM  = 30;
  localparam int unsigned SYM_LIM = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lost = 1'b0, wsel = 1'b0, lh = 1'b0, ien = 1'b0, rd = 1'b0;
  logic alarm, sts, irq;
  int checks = 0, errors = 0, irq_seen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alos_timer #(.SYNC_STAGES(2), .CLK_KHZ(20), .MS_WIN_US(1500),
               .SYM_CYC(2), .SYM_WIN(12)) u_alos_timer (
    .clk_i(clk), .rst_ni(rst_n), .lost_i(lost), .win_sel_i(wsel),
    .long_haul_i(lh), .irq_en_i(ien), .rd_stb_i(rd),
    .alarm_o(alarm), .status_o(sts), .irq_o(irq)
  );

  // fields: [15] win_sel, [14] long_haul, [13] expected alarm, [7:0] edges waited
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 5'd0, 8'(MS_LIM + 1)},
    {1'b0, 1'b0, 1'b1, 5'd0, 8'(MS_LIM + 2)},
    {1'b1, 1'b0, 1'b0, 5'd0, 8'(SYM_LIM + 1)},
    {1'b1, 1'b0, 1'b1, 5'd0, 8'(SYM_LIM + 2)},
    {1'b1, 1'b0, 1'b1, 5'd0, 8'd60},
    {1'b0, 1'b1, 1'b0, 5'd0, 8'd60}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_pulse();
    rd = 1'b1;
    wait_n(1);
    rd = 1'b0;
  endtask

  always @(negedge clk) if (rst_n && irq) irq_seen++;

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    chk("R9 alarm", alarm, 1'b0);
    chk("R9 status", sts, 1'b0);
    chk("R9 irq", irq, 1'b0);
    rst_n = 1'b1;
    wait_n(2);

    foreach (VEC[i]) begin
      lost = 1'b0; wsel = VEC[i][15]; lh = VEC[i][14];
      wait_n(4);
      lost = 1'b1;
      wait_n(int'(VEC[i][7:0]));
      chk(VEC[i][14] ? "R5 table" : (VEC[i][15] ? "R2 table" : "R1 table"),
          alarm, VEC[i][13]);
    end
    lost = 1'b0; lh = 1'b0; wsel = 1'b0;
    checks++;
    if (irq_seen != 0) begin
      errors++;
      $display("FAIL R8 masked: actual %0d pulses expected 0", irq_seen);
    end

    // R3 restart after a one-cycle gap
    wait_n(4);
    lost = 1'b1; wait_n(20);
    lost = 1'b0; wait_n(1);
    lost = 1'b1;
    wait_n(MS_LIM + 1); chk("R3 before", alarm, 1'b0);
    wait_n(1);          chk("R1 after restart", alarm, 1'b1);

    // R4 clear latency
    lost = 1'b0;
    wait_n(2); chk("R4 still set", alarm, 1'b1);
    wait_n(1); chk("R4 cleared", alarm, 1'b0);

    // R6 hold, R7 clear on read
    wait_n(3); chk("R6 sticky hold", sts, 1'b1);
    read_pulse(); chk("R7 cleared", sts, 1'b0);

    // R8 interrupt with enable, R6 set timing
    ien = 1'b1; lost = 1'b1;
    wait_n(MS_LIM + 2);
    chk("R8 irq not yet", irq, 1'b0);
    chk("R6 status not yet", sts, 1'b0);
    wait_n(1);
    chk("R8 irq pulse", irq, 1'b1);
    chk("R6 status set", sts, 1'b1);
    wait_n(1); chk("R8 irq single", irq, 1'b0);

    // R7 read while active
    read_pulse(); chk("R7 read clears", sts, 1'b0);
    wait_n(1);    chk("R7 re-set", sts, 1'b1);

    // R5 long haul while active
    lh = 1'b1;
    wait_n(1); chk("R5 alarm off", alarm, 1'b0);
    wait_n(5); chk("R5 stays off", alarm, 1'b0);
    read_pulse();
    wait_n(3); chk("R5 status blocked", sts, 1'b0);
    chk("R5 irq blocked", irq, 1'b0);
    lh = 1'b0;
    wait_n(MS_LIM - 1); chk("R5 retimed before", alarm, 1'b0);
    wait_n(1);          chk("R5 retimed after", alarm, 1'b1);

    lost = 1'b0; ien = 1'b0;
    wait_n(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule